// File: doc/BRIEF.md
# Dual-Clock FIFO with Selectable Flag Timing

This block buffers one direction of a bidirectional link. Words enter on a write port clocked by `wclk` and leave on a read port clocked by `rclk`. The two clocks run freely and may be unrelated or the same clock. Pointers cross between the domains as Gray code through two-flop synchronizers. The memory is a register array, and its depth is set by the parameter `AW`.

A mode input is captured at master reset. It selects one of two timings:

- **Standard timing.** A word is read by request. `rflag` reports that the FIFO is not empty, and `wflag` reports that it is not full.
- **Fall-through timing.** The oldest word is moved ahead into the output register without a request. `rflag` then reports that the word on `rdata` is valid, and `wflag` reports that the block can accept input.

Two threshold flags, `aempty` and `afull`, compare the fill level against two offsets. The offsets come from one of five presets chosen at master reset, or from a serial load or a parallel load.

A partial reset empties the FIFO and keeps the configuration. A retransmit request rewinds the read side to the first word written since the last reset.

Top module: `dcfifo`

## Requirements
- R1: In standard mode, asserting `rd_en` at a `rclk` edge while data is present puts the oldest word on `rdata` after that edge, in write order. `rdata` does not change on any edge without `rd_en`.
- R2: In fall-through mode, the oldest word appears on `rdata` with `rflag` high, with no `rd_en`. Asserting `rd_en` discards that word, and the next word takes its place.
- R3: `rflag` low means no read is possible, and `wflag` low means no write is possible. A write while full is ignored, and a read while empty leaves `rdata` unchanged.
- R4: Capacity is `2**AW` words in standard mode and `2**AW + 1` words in fall-through mode, counting the output register.
- R5: `aempty` is high when the number of words held (memory plus a valid output word) is less than or equal to the almost-empty offset.
- R6: `afull` is high when the free memory slots (`2**AW` minus the words in memory) are less than or equal to the almost-full offset.
- R7: At master reset, `osel_in` values 0, 1, 2, 3 and 4 select the offset 8, 16, 64, 256 and 1024 respectively, for both flags. Any offset above `2**AW - 1` saturates to `2**AW - 1`. Values 5 to 7 also start at this saturated value until a load occurs.
- R8: With `osel_in` = 5 at master reset, each `wclk` edge with `sen` high shifts `sdin` into the offsets. The first `AW` bits, most significant bit first, form the almost-empty offset, and the next `AW` bits form the almost-full offset. Bits after the `2*AW`-th are ignored.
- R9: With `osel_in` = 6 or 7 at master reset, a `wclk` edge with `pload` high loads the almost-empty offset from `wdata[15:0]` and the almost-full offset from `wdata[31:16]`, both saturated as in R7. The word on that edge is not stored.
- R10: While `mrst_n` is low, the block empties and latches `fwft_in` and `osel_in`. A pulse on `prst_n` empties the block and keeps the mode and the current offsets.
- R11: A `rclk` edge with `rt` high rewinds the read side. The next reads return the words from the first one written since the last reset.
- R12: A change of `fwft_in` after master reset has no effect on the timing mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| mrst_n | input | 1 | Master reset, active low; latches configuration |
| prst_n | input | 1 | Partial reset, active low; keeps configuration |
| fwft_in | input | 1 | Timing mode at master reset: 1 = fall-through |
| osel_in | input | 3 | Offset source at master reset |
| sen | input | 1 | Serial offset shift enable (write clock) |
| sdin | input | 1 | Serial offset bit |
| pload | input | 1 | Parallel offset load from `wdata` |
| wr_en | input | 1 | Write request |
| wdata | input | DW | Write data |
| rd_en | input | 1 | Read request / advance |
| rt | input | 1 | Retransmit request (read clock) |
| rdata | output | DW | Read data |
| rflag | output | 1 | Read possible (not empty / output ready) |
| wflag | output | 1 | Write possible (not full / input ready) |
| aempty | output | 1 | Almost-empty |
| afull | output | 1 | Almost-full |

## Verification
The bench builds the block with `AW` = 4 and `DW` = 36, so the memory holds sixteen words. This makes it practical to sweep every fill level from empty to full under each offset source. It also brings saturation into view: preset 8 stays at 8, while the presets 16 through 1024 all saturate to 15. The write clock and the read clock run at different periods, so every flag is checked after the pointers have crossed the synchronizers in both directions.

// File: rtl/dcfifo.sv
module dcfifo #(
  parameter int DW = 36,
  parameter int AW = 4
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          mrst_n,
  input  logic          prst_n,
  input  logic          fwft_in,
  input  logic [2:0]    osel_in,
  input  logic          sen,
  input  logic          sdin,
  input  logic          pload,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  input  logic          rd_en,
  input  logic          rt,
  output logic [DW-1:0] rdata,
  output logic          rflag,
  output logic          wflag,
  output logic          aempty,
  output logic          afull
);
  localparam int DEPTH = 1 << AW;
  localparam int PW    = AW + 1;
  localparam int SN    = 2 * AW;
  localparam int CW    = $clog2(SN + 1);

  function automatic logic [PW-1:0] b2g(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  function automatic logic [AW-1:0] sat(input logic [15:0] v);
    return (v > 16'(DEPTH - 1)) ? AW'(DEPTH - 1) : v[AW-1:0];
  endfunction

  function automatic logic [15:0] preset(input logic [2:0] s);
    case (s)
      3'd0:    return 16'd8;
      3'd1:    return 16'd16;
      3'd2:    return 16'd64;
      3'd3:    return 16'd256;
      default: return 16'd1024;
    endcase
  endfunction

  logic rst_n;
  assign rst_n = mrst_n & prst_n;

  // configuration, write clock domain
  logic          fwft;
  logic [2:0]    osel;
  logic [AW-1:0] ae_off, af_off;
  logic [SN-1:0] sreg;
  logic [CW-1:0] scnt;
  logic [SN-1:0] sreg_nx;
  logic          pmode;

  assign sreg_nx = {sreg[SN-2:0], sdin};
  assign pmode   = (osel[2:1] == 2'b11);

  always_ff @(posedge wclk) begin
    if (!mrst_n) begin
      fwft   <= fwft_in;
      osel   <= osel_in;
      sreg   <= '0;
      scnt   <= '0;
      ae_off <= sat(preset(osel_in));
      af_off <= sat(preset(osel_in));
    end else if (osel == 3'd5) begin
      if (sen && scnt != CW'(SN)) begin
        sreg <= sreg_nx;
        scnt <= scnt + CW'(1);
        if (scnt == CW'(SN - 1)) begin
          ae_off <= sreg_nx[SN-1:AW];
          af_off <= sreg_nx[AW-1:0];
        end
      end
    end else if (pmode && pload) begin
      ae_off <= sat(wdata[15:0]);
      af_off <= sat(wdata[31:16]);
    end
  end

  // storage and write side
  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wbin, wgray, rg1, rg2, rgray;
  logic [PW-1:0] wcount, wfree;
  logic          full, wpush;

  assign wcount = wbin - g2b(rg2);
  assign full   = (wcount == PW'(DEPTH));
  assign wfree  = PW'(DEPTH) - wcount;
  assign wpush  = wr_en && !full && !(pmode && pload);
  assign wflag  = !full;
  assign afull  = (wfree <= {1'b0, af_off});

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      wbin  <= '0;
      wgray <= '0;
      rg1   <= '0;
      rg2   <= '0;
    end else begin
      rg1 <= rgray;
      rg2 <= rg1;
      if (wpush) begin
        wbin  <= wbin + PW'(1);
        wgray <= b2g(wbin + PW'(1));
      end
    end
  end

  always_ff @(posedge wclk) begin
    if (wpush) mem[wbin[AW-1:0]] <= wdata;
  end

  // read side
  logic [PW-1:0] rbin, wg1, wg2, mcount, rcnt;
  logic          iempty, or_q, rload;

  assign mcount = g2b(wg2) - rbin;
  assign iempty = (mcount == '0);
  assign rload  = fwft ? (!iempty && (!or_q || rd_en)) : (rd_en && !iempty);
  assign rcnt   = mcount + PW'(or_q);
  assign rflag  = fwft ? or_q : !iempty;
  assign aempty = (rcnt <= {1'b0, ae_off});

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      rbin  <= '0;
      rgray <= '0;
      wg1   <= '0;
      wg2   <= '0;
      or_q  <= 1'b0;
      rdata <= '0;
    end else begin
      wg1 <= wgray;
      wg2 <= wg1;
      if (rt) begin
        rbin  <= '0;
        rgray <= '0;
        or_q  <= 1'b0;
      end else begin
        if (rload) begin
          rdata <= mem[rbin[AW-1:0]];
          rbin  <= rbin + PW'(1);
          rgray <= b2g(rbin + PW'(1));
        end
        if (fwft) or_q <= rload | (or_q & !rd_en);
      end
    end
  end
endmodule

// File: rtl/dcfifo_chk.sv
module dcfifo_chk #(
  parameter int DW = 36,
  parameter int AW = 4
) (
  input logic          wclk,
  input logic          rclk,
  input logic          rst_n,
  input logic          fwft,
  input logic          rd_en,
  input logic          rt,
  input logic          full,
  input logic          iempty,
  input logic          or_q,
  input logic [AW:0]   wbin,
  input logic [AW:0]   rbin,
  input logic [AW:0]   wcount,
  input logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  a_r3_full_write_dropped: assert property (@(posedge wclk) disable iff (!rst_n)
    full |=> $stable(wbin));

  a_r3_empty_read_dropped: assert property (@(posedge rclk) disable iff (!rst_n)
    (iempty && !rt) |=> $stable(rbin));

  a_r4_no_overflow: assert property (@(posedge wclk) disable iff (!rst_n)
    wcount <= (AW+1)'(DEPTH));

  a_r11_rewind: assert property (@(posedge rclk) disable iff (!rst_n)
    rt |=> (rbin == '0));

  a_r2_word_held: assert property (@(posedge rclk) disable iff (!rst_n)
    (fwft && or_q && !rd_en && !rt) |=> (or_q && $stable(rdata)));

  a_r1_no_unrequested_read: assert property (@(posedge rclk) disable iff (!rst_n)
    (!fwft && !rd_en) |=> $stable(rdata));
endmodule

bind dcfifo dcfifo_chk #(.DW(DW), .AW(AW)) u_chk (
  .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .fwft(fwft), .rd_en(rd_en),
  .rt(rt), .full(full), .iempty(iempty), .or_q(or_q), .wbin(wbin),
  .rbin(rbin), .wcount(wcount), .rdata(rdata)
);

// File: tb/sim_dcfifo.sv
module sim_dcfifo;
  localparam int DW = 36;
  localparam int AW = 4;
  localparam int DEPTH = 1 << AW;

  logic wclk = 0, rclk = 0;
  logic mrst_n = 0, prst_n = 1, fwft_in = 0, sen = 0, sdin = 0, pload = 0;
  logic wr_en = 0, rd_en = 0, rt = 0;
  logic [2:0] osel_in = 0;
  logic [DW-1:0] wdata = 0;
  logic [DW-1:0] rdata;
  logic rflag, wflag, aempty, afull;
  int total = 0, bad = 0;

  always #2.5 wclk = ~wclk;
  always #3.5 rclk = ~rclk;

  dcfifo #(.DW(DW), .AW(AW)) u0 (
    .wclk(wclk), .rclk(rclk), .mrst_n(mrst_n), .prst_n(prst_n), .fwft_in(fwft_in),
    .osel_in(osel_in), .sen(sen), .sdin(sdin), .pload(pload), .wr_en(wr_en),
    .wdata(wdata), .rd_en(rd_en), .rt(rt), .rdata(rdata), .rflag(rflag),
    .wflag(wflag), .aempty(aempty), .afull(afull)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (8) @(negedge rclk);
  endtask

  task automatic mreset(input logic f, input logic [2:0] s);
    @(negedge wclk);
    mrst_n = 0; fwft_in = f; osel_in = s;
    repeat (4) @(negedge wclk);
    mrst_n = 1;
    settle();
  endtask

  task automatic push(input int n, input int base);
    for (int i = 0; i < n; i++) begin
      @(negedge wclk);
      wr_en = 1; wdata = DW'(base + i);
    end
    @(negedge wclk);
    wr_en = 0;
  endtask

  task automatic pop_std(input string req, input int n, input int base);
    for (int i = 0; i < n; i++) begin
      @(negedge rclk); rd_en = 1;
      @(negedge rclk); rd_en = 0;
      check(req, rdata, 64'(base + i));
    end
  endtask

  task automatic sweep(input string req, input int aeo, input int afo, input int base);
    for (int k = 0; k <= DEPTH; k++) begin
      check({req, " R3 rflag"}, rflag, k > 0);
      check({req, " R4 wflag"}, wflag, k < DEPTH);
      check({req, " R5 aempty"}, aempty, k <= aeo);
      check({req, " R6 afull"}, afull, (DEPTH - k) <= afo);
      if (k < DEPTH) begin push(1, base + k); settle(); end
    end
  endtask

  initial begin
    repeat (100000) @(posedge wclk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R10 reset state
    mreset(0, 0);
    check("R10 rflag", rflag, 0);
    check("R10 wflag", wflag, 1);
    check("R10 aempty", aempty, 1);
    check("R10 afull", afull, 0);
    check("R10 rdata", rdata, 0);

    // R7 preset 8, full sweep, then overflow write and drain
    sweep("R7 preset8", 8, 8, 16);
    push(1, 999); settle();
    pop_std("R1 order", DEPTH, 16);
    settle();
    check("R3 empty after drain", rflag, 0);
    @(negedge rclk); rd_en = 1; @(negedge rclk); rd_en = 0;
    check("R3 read while empty", rdata, 64'(16 + DEPTH - 1));

    // R7 larger presets saturate to DEPTH-1
    for (int s = 1; s <= 4; s++) begin
      mreset(0, 3'(s));
      check("R7 sat aempty at 0", aempty, 1);
      check("R7 sat afull at 0", afull, 0);
      push(1, 0); settle();
      check("R7 sat afull at 1", afull, 1);
      push(DEPTH - 1, 1); settle();
      check("R7 sat aempty at full", aempty, 0);
    end

    // R9 parallel load, word not stored
    mreset(0, 6);
    @(negedge wclk); pload = 1; wr_en = 1; wdata = {4'h0, 16'd5, 16'd3};
    @(negedge wclk); pload = 0; wr_en = 0;
    settle();
    check("R9 load word not stored", rflag, 0);
    sweep("R9 parallel", 3, 5, 40);
    pop_std("R9 data", DEPTH, 40);

    // R9 saturation of loaded values
    mreset(0, 7);
    @(negedge wclk); pload = 1; wdata = {4'h0, 16'd2, 16'd100};
    @(negedge wclk); pload = 0;
    settle();
    sweep("R9 saturated", DEPTH - 1, 2, 60);

    // R8 serial load: ae=2 then af=6, msb first, then extra ignored bits
    mreset(0, 5);
    begin
      logic [11:0] bits;
      bits = {4'b0010, 4'b0110, 4'b1111};
      for (int i = 11; i >= 0; i--) begin
        @(negedge wclk); sen = 1; sdin = bits[i];
      end
      @(negedge wclk); sen = 0;
    end
    settle();
    sweep("R8 serial", 2, 6, 80);

    // R10 partial reset empties and keeps offsets
    @(negedge wclk); prst_n = 0;
    repeat (2) @(negedge wclk); prst_n = 1;
    settle();
    check("R10 partial empties", rflag, 0);
    check("R10 partial wflag", wflag, 1);
    sweep("R10 partial keeps", 2, 6, 120);

    // R11 retransmit
    mreset(0, 0);
    push(5, 100); settle();
    pop_std("R11 first pass", 3, 100);
    @(negedge rclk); rt = 1; @(negedge rclk); rt = 0;
    settle();
    check("R11 data again", rflag, 1);
    pop_std("R11 replay", 5, 100);
    settle();
    check("R11 empty after replay", rflag, 0);

    // R2 and R4 fall-through
    mreset(1, 0);
    push(1, 200); settle();
    check("R2 word ready", rflag, 1);
    check("R2 word shown", rdata, 200);
    push(DEPTH - 1, 201); settle();
    check("R4 fwft room left", wflag, 1);
    push(1, 200 + DEPTH); settle();
    check("R4 fwft full", wflag, 0);
    push(1, 777); settle();
    for (int i = 0; i <= DEPTH; i++) begin
      check("R2 ready", rflag, 1);
      check("R2 data", rdata, 64'(200 + i));
      @(negedge rclk); rd_en = 1; @(negedge rclk); rd_en = 0;
      repeat (2) @(negedge rclk);
    end
    settle();
    check("R2 drained", rflag, 0);

    // R12 mode change after reset ignored
    mreset(0, 0);
    fwft_in = 1;
    push(1, 300); settle();
    check("R12 no fall-through", rdata, 0);
    check("R12 rflag", rflag, 1);
    pop_std("R12 read", 1, 300);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule